// File: doc/BRIEF.md
# Burst Ramp and Power-Level Gain Generator

This block produces the gain word by which one carrier's digital IF samples are scaled during a transmit burst. When a burst begins, the gain rises smoothly from zero to a programmed level along a half period of a cosine (a raised-sine edge). It then holds that level for the burst. When the burst ends, it falls back to zero along the mirror-image raised-cosine edge. The edge shape is not read from a stored table. A two-tap recursive sinusoidal oscillator computes it in real time, and the result is scaled by the burst's amplitude and shifted by a dc term equal to half that amplitude.

The burst level is selected by an 8-bit power code. The upper five bits give attenuation in 2 dB steps and the lower three bits give attenuation in 0.25 dB steps. Total attenuation is capped at 32 dB below full scale. The code is sampled only when a ramp-up trigger is accepted, so the level can change from one burst to the next but never within a burst. The oscillator is re-seeded at the start of every edge, so rounding error cannot build up across bursts. The multiplier that applies the gain to the IF stream is outside this block.

Top module: `burst_ramp_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `gain_o` is 0 and `steady_o` is 1.
- R2: Level encoding. `pwr_code_i[7:3]` counts 2 dB steps and `pwr_code_i[2:0]` counts 0.25 dB steps, so the code value is the attenuation in quarter-dB units. That value is capped at 128 (32 dB). The held level is round(65535 · 10^(−value/80)), within ±1.
- R3: A ramp-up trigger accepted in the idle state starts the rising edge. The first sample appears on `gain_o` two clock edges after the trigger edge. Sample n, for n = 0..N−1 with N = `RAMP_LEN`, is within 12 LSB of L·(1−cos(πn/N))/2. `steady_o` is 0 for exactly those N samples.
- R4: After the N rising samples, `gain_o` equals the latched level L exactly and `steady_o` is 1. Both stay so until a ramp-down trigger is accepted.
- R5: A ramp-down trigger accepted while holding starts the falling edge. The first sample appears one clock edge after the trigger edge. Sample n is within 12 LSB of L·(1+cos(πn/N))/2, and `steady_o` is 0 for those N samples.
- R6: After the N falling samples, `gain_o` is 0 and `steady_o` is 1 until the next accepted ramp-up trigger.
- R7: The power code is sampled only on the accepted ramp-up trigger. Changing it at any other time has no effect on the running burst.
- R8: A ramp-up trigger is accepted only in the idle state, and a ramp-down trigger only while holding. Triggers at any other time, including during either edge, are ignored.
- R9: Rising samples never decrease, falling samples never increase, and no ramp sample exceeds the latched level.
- R10: Two bursts with the same power code produce bit-identical rising edges.
- R11: Successive bursts with different power codes hold different levels, each set by its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ramp_up_i | input | 1 | Start-of-burst trigger |
| ramp_down_i | input | 1 | End-of-burst trigger |
| pwr_code_i | input | CODE_W | Attenuation code: coarse 2 dB field in the upper five bits, fine 0.25 dB field in the lower three |
| gain_o | output | GAIN_W | Unsigned gain word for the IF multiplier |
| steady_o | output | 1 | High while the gain is a constant level (idle or hold), low during an edge |

## Verification
A wrong oscillator coefficient or seed appears at the ports as edge samples that drift away from the ideal half-cosine. The drift can be seen within a few dozen samples, and it ends in a visible step where the edge meets the hold level. A faulty sample counter changes how many cycles `steady_o` stays low, and this shows on the cycle the edge should end. A wrong latched level or a mis-decoded code field appears at once in the first held value after the rising edge. A trigger that leaks into a running edge shows as a restart or an early step within one sample.

// File: rtl/burst_ramp_pkg.sv
package burst_ramp_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_ARM  = 3'd1,
    ST_UP   = 3'd2,
    ST_HOLD = 3'd3,
    ST_DOWN = 3'd4
  } ramp_st_t;

  localparam real PI_R   = 3.14159265358979323846;
  localparam real LN10_R = 2.302585092994046;

  // Power series of cosine, accurate for the small angles used here.
  function automatic real cos_series(input real x);
    real term;
    real acc;
    term = 1.0;
    acc  = 1.0;
    for (int k = 1; k < 10; k++) begin
      term = -term * x * x / (real'(2 * k - 1) * real'(2 * k));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Power series of the exponential, for arguments down to about -4.
  function automatic real exp_series(input real x);
    real term;
    real acc;
    term = 1.0;
    acc  = 1.0;
    for (int k = 1; k < 48; k++) begin
      term = term * x / real'(k);
      acc  = acc + term;
    end
    return acc;
  endfunction

endpackage

// File: rtl/burst_ramp_level_rom.sv
module burst_ramp_level_rom
  import burst_ramp_pkg::*;
#(
  parameter int GAIN_W      = 16,
  parameter int CODE_W      = 8,
  parameter int MAX_ATTEN_Q = 128
) (
  input  logic              clk,
  input  logic [CODE_W-1:0] code_i,
  output logic [GAIN_W-1:0] level_o
);

  localparam int DEPTH  = MAX_ATTEN_Q + 1;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam longint FULL = (longint'(1) << GAIN_W) - 1;

  // Linear amplitude for an attenuation of q quarter-dB steps.
  function automatic logic [GAIN_W-1:0] level_of(input int q);
    real a;
    a = exp_series(-real'(q) * LN10_R / 80.0);
    return GAIN_W'(longint'(real'(FULL) * a));
  endfunction

  logic [GAIN_W-1:0] rom_mem [DEPTH];
  logic [ADDR_W-1:0] addr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [GAIN_W-1:0] ENTRY = level_of(i);
    assign rom_mem[i] = ENTRY;
  end

  always_comb begin
    if (int'(code_i) > MAX_ATTEN_Q) addr = ADDR_W'(MAX_ATTEN_Q);
    else                            addr = ADDR_W'(code_i);
  end

  // Registered read so the table maps onto a synchronous ROM.
  always_ff @(posedge clk) begin
    level_o <= rom_mem[addr];
  end

endmodule

// File: rtl/burst_ramp_osc.sv
module burst_ramp_osc #(
  parameter int RAMP_LEN = 728,
  parameter int OSC_FRAC = 30,
  parameter int Y_W      = OSC_FRAC + 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  seed_i,
  input  logic                  step_i,
  output logic signed [Y_W-1:0] y_o
);

  localparam int  MUL_W = 2 * Y_W;
  localparam real THETA = burst_ramp_pkg::PI_R / real'(RAMP_LEN);
  localparam real COS_T = burst_ramp_pkg::cos_series(THETA);
  localparam real SCALE = real'(longint'(1) << OSC_FRAC);

  localparam logic signed [Y_W-1:0]   ONE_Q  = Y_W'(longint'(1) << OSC_FRAC);
  localparam logic signed [Y_W-1:0]   C_Q    = Y_W'(longint'(COS_T * SCALE));
  localparam logic signed [Y_W-1:0]   K_Q    = Y_W'(longint'(2.0 * COS_T * SCALE));
  localparam logic signed [MUL_W-1:0] HALF_Q = MUL_W'(longint'(1) << (OSC_FRAC - 1));

  logic signed [Y_W-1:0]   y_cur;
  logic signed [Y_W-1:0]   y_prev;
  logic signed [Y_W-1:0]   y_nxt;
  logic signed [MUL_W-1:0] mul;

  // y[n] = 2cos(theta) * y[n-1] - y[n-2], rounded to OSC_FRAC fraction bits
  always_comb begin
    mul   = MUL_W'(K_Q) * MUL_W'(y_cur);
    y_nxt = Y_W'((mul + HALF_Q) >>> OSC_FRAC) - y_prev;
  end

  // Seeds: y[0] = cos(0), y[-1] = cos(-theta)
  always_ff @(posedge clk) begin
    if (rst || seed_i) begin
      y_cur  <= ONE_Q;
      y_prev <= C_Q;
    end else if (step_i) begin
      y_prev <= y_cur;
      y_cur  <= y_nxt;
    end
  end

  assign y_o = y_cur;

endmodule

// File: rtl/burst_ramp_seq.sv
module burst_ramp_seq
  import burst_ramp_pkg::*;
#(
  parameter int RAMP_LEN = 728,
  parameter int CNT_W    = $clog2(RAMP_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_i,
  input  logic             down_i,
  output ramp_st_t         st_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             seed_o,
  output logic             step_o,
  output logic             load_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(RAMP_LEN - 1);

  ramp_st_t         st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_OFF: if (up_i) st_q <= ST_ARM;
        ST_ARM: begin
          st_q  <= ST_UP;
          cnt_q <= '0;
        end
        ST_UP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= ST_HOLD;
        end
        ST_HOLD: if (down_i) begin
          st_q  <= ST_DOWN;
          cnt_q <= '0;
        end
        ST_DOWN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= ST_OFF;
        end
        default: st_q <= ST_OFF;
      endcase
    end
  end

  assign st_o   = st_q;
  assign cnt_o  = cnt_q;
  assign load_o = (st_q == ST_ARM);
  assign seed_o = (st_q == ST_ARM) || ((st_q == ST_HOLD) && down_i);
  assign step_o = (st_q == ST_UP) || (st_q == ST_DOWN);

endmodule

// File: rtl/burst_ramp_shape.sv
module burst_ramp_shape #(
  parameter int GAIN_W   = 16,
  parameter int OSC_FRAC = 30,
  parameter int Y_W      = OSC_FRAC + 3
) (
  input  logic [GAIN_W-1:0]     level_i,
  input  logic signed [Y_W-1:0] y_i,
  input  logic                  fall_i,
  output logic [GAIN_W-1:0]     shaped_o
);

  localparam int PROD_W = GAIN_W + Y_W + 1;
  localparam logic signed [PROD_W-1:0] RND_Q = PROD_W'(longint'(1) << OSC_FRAC);

  logic signed [PROD_W-1:0] lvl_ext;
  logic signed [PROD_W-1:0] y_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] dc_term;
  logic signed [PROD_W-1:0] num;
  logic signed [PROD_W-1:0] rnd;

  // gain = L/2 -/+ (L/2)*cos : dc term L*ONE, swing L*y, both halved on the shift
  always_comb begin
    lvl_ext = $signed({{(PROD_W - GAIN_W){1'b0}}, level_i});
    y_ext   = {{(PROD_W - Y_W){y_i[Y_W-1]}}, y_i};
    prod    = lvl_ext * y_ext;
    dc_term = lvl_ext <<< OSC_FRAC;
    num     = fall_i ? (dc_term + prod) : (dc_term - prod);
    rnd     = (num + RND_Q) >>> (OSC_FRAC + 1);
    if (rnd < 0)             shaped_o = '0;
    else if (rnd > lvl_ext)  shaped_o = level_i;
    else                     shaped_o = rnd[GAIN_W-1:0];
  end

endmodule

// File: rtl/burst_ramp_gen.sv
module burst_ramp_gen
  import burst_ramp_pkg::*;
#(
  parameter int GAIN_W      = 16,
  parameter int CODE_W      = 8,
  parameter int RAMP_LEN    = 728,
  parameter int OSC_FRAC    = 30,
  parameter int MAX_ATTEN_Q = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ramp_up_i,
  input  logic              ramp_down_i,
  input  logic [CODE_W-1:0] pwr_code_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              steady_o
);

  localparam int CNT_W = $clog2(RAMP_LEN);
  localparam int Y_W   = OSC_FRAC + 3;

  ramp_st_t              st;
  logic [CNT_W-1:0]      cnt;
  logic                  seed;
  logic                  step;
  logic                  load;
  logic [GAIN_W-1:0]     rom_level;
  logic [GAIN_W-1:0]     level_q;
  logic [GAIN_W-1:0]     shaped;
  logic signed [Y_W-1:0] y;

  burst_ramp_seq #(.RAMP_LEN(RAMP_LEN), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .up_i(ramp_up_i), .down_i(ramp_down_i),
    .st_o(st), .cnt_o(cnt), .seed_o(seed), .step_o(step), .load_o(load)
  );

  burst_ramp_level_rom #(.GAIN_W(GAIN_W), .CODE_W(CODE_W), .MAX_ATTEN_Q(MAX_ATTEN_Q)) u_rom (
    .clk(clk), .code_i(pwr_code_i), .level_o(rom_level)
  );

  burst_ramp_osc #(.RAMP_LEN(RAMP_LEN), .OSC_FRAC(OSC_FRAC), .Y_W(Y_W)) u_osc (
    .clk(clk), .rst(rst), .seed_i(seed), .step_i(step), .y_o(y)
  );

  burst_ramp_shape #(.GAIN_W(GAIN_W), .OSC_FRAC(OSC_FRAC), .Y_W(Y_W)) u_shape (
    .level_i(level_q), .y_i(y), .fall_i(st == ST_DOWN), .shaped_o(shaped)
  );

  // Burst level: latched once per burst, in the cycle after the trigger
  always_ff @(posedge clk) begin
    if (rst)       level_q <= '0;
    else if (load) level_q <= rom_level;
  end

  // Output stage: edges are kept monotonic against recursion drift
  always_ff @(posedge clk) begin
    if (rst) begin
      gain_o   <= '0;
      steady_o <= 1'b1;
    end else begin
      unique case (st)
        ST_UP: begin
          gain_o   <= (shaped > gain_o) ? shaped : gain_o;
          steady_o <= 1'b0;
        end
        ST_HOLD: begin
          gain_o   <= level_q;
          steady_o <= 1'b1;
        end
        ST_DOWN: begin
          gain_o   <= (shaped < gain_o) ? shaped : gain_o;
          steady_o <= 1'b0;
        end
        default: begin
          gain_o   <= '0;
          steady_o <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/burst_ramp_gen_chk.sv
module burst_ramp_gen_chk
  import burst_ramp_pkg::*;
#(
  parameter int GAIN_W   = 16,
  parameter int RAMP_LEN = 728,
  parameter int CNT_W    = $clog2(RAMP_LEN)
) (
  input logic              clk,
  input logic              rst,
  input ramp_st_t          st,
  input logic [CNT_W-1:0]  cnt,
  input logic [GAIN_W-1:0] level_q,
  input logic [GAIN_W-1:0] gain_o,
  input logic              steady_o
);

  localparam int RUN_W = $clog2(RAMP_LEN + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || steady_o)      run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
  end

  // R3: each edge keeps steady_o low for exactly RAMP_LEN samples
  assert_ramp_len_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(steady_o) |-> (run_q == RUN_W'(RAMP_LEN)));

  // R4: holding presents the latched level
  assert_hold_level_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD) |=> (gain_o == level_q) && steady_o);

  // R6: idle and arming keep the output off
  assert_idle_off_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFF || st == ST_ARM) |=> (gain_o == '0) && steady_o);

  // R7: the level changes only in the arming cycle
  assert_level_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (st != ST_ARM) |=> $stable(level_q));

  // R9: rising edge never decreases
  assert_rise_monotone_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_UP && cnt != '0) |=> (gain_o >= $past(gain_o)));

  // R9: falling edge never increases
  assert_fall_monotone_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DOWN && cnt != '0) |=> (gain_o <= $past(gain_o)));

  // R9: ramp samples stay at or below the burst level
  assert_ramp_bound_R9: assert property (@(posedge clk) disable iff (rst)
    !steady_o |-> (gain_o <= level_q));

endmodule

bind burst_ramp_gen burst_ramp_gen_chk #(
  .GAIN_W(GAIN_W), .RAMP_LEN(RAMP_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .st(st), .cnt(cnt), .level_q(level_q),
  .gain_o(gain_o), .steady_o(steady_o)
);

// File: tb/burst_ramp_gen_tb.sv
module burst_ramp_gen_tb;

  localparam int  N    = 728;
  localparam int  TOL  = 12;
  localparam real PI_V = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ramp_up_i = 1'b0;
  logic        ramp_down_i = 1'b0;
  logic [7:0]  pwr_code_i = 8'h00;
  logic [15:0] gain_o;
  logic        steady_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int ref_up [N];
  int cur_up [N];

  always #5 clk = ~clk;

  burst_ramp_gen u_dut (
    .clk(clk), .rst(rst), .ramp_up_i(ramp_up_i), .ramp_down_i(ramp_down_i),
    .pwr_code_i(pwr_code_i), .gain_o(gain_o), .steady_o(steady_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int level_exp(input int code);
    int q;
    q = (code > 128) ? 128 : code;
    return $rtoi(65535.0 * $pow(10.0, -real'(q) / 80.0) + 0.5);
  endfunction

  function automatic int ramp_exp(input int lvl, input int n, input bit fall);
    real c;
    real v;
    c = $cos(PI_V * real'(n) / real'(N));
    v = fall ? real'(lvl) * (1.0 + c) / 2.0 : real'(lvl) * (1.0 - c) / 2.0;
    return $rtoi(v + 0.5);
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(gain_o == 0 && steady_o, "R1 during reset", gain_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(gain_o == 0 && steady_o, "R1 after reset", gain_o, 0);
  endtask

  task automatic t_idle_down_ignored();
    @(negedge clk); ramp_down_i = 1'b1;
    @(negedge clk); ramp_down_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(gain_o == 0 && steady_o, "R8 down in idle ignored", gain_o, 0);
    end
  endtask

  // One full burst: rising edge, hold, falling edge, idle.
  task automatic t_burst(input logic [7:0] code, input bit poke, input int prev_lvl);
    int lvl;
    int prev;
    int e;
    int hv;
    lvl = level_exp(int'(code));
    @(negedge clk); pwr_code_i = code; ramp_up_i = 1'b1;
    @(negedge clk); ramp_up_i = 1'b0;
    if (poke) pwr_code_i = ~code;                    // R7: code change after trigger
    @(negedge clk);
    chk(gain_o == 0 && steady_o, "R3 arm cycle still off", gain_o, 0);
    prev = 0;
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      e = ramp_exp(lvl, n, 1'b0);
      chk(iabs(int'(gain_o) - e) <= TOL && !steady_o, "R3 rising sample", gain_o, e);
      chk(int'(gain_o) >= prev && int'(gain_o) <= lvl + 1, "R9 rising order", gain_o, prev);
      prev = int'(gain_o);
      cur_up[n] = int'(gain_o);
      if (poke && n == 100) begin ramp_up_i = 1'b1; ramp_down_i = 1'b1; end  // R8
      if (poke && n == 101) begin ramp_up_i = 1'b0; ramp_down_i = 1'b0; end
    end
    @(negedge clk);
    hv = int'(gain_o);
    chk(steady_o, "R4 steady after rising edge", steady_o, 1);
    chk(iabs(hv - lvl) <= 1, "R2 R7 held level", hv, lvl);
    if (prev_lvl >= 0)
      chk(hv != prev_lvl, "R11 level differs from previous burst", hv, prev_lvl);
    if (poke) begin ramp_up_i = 1'b1; pwr_code_i = 8'h40; end   // R8, R7 during hold
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      ramp_up_i = 1'b0;
      chk(int'(gain_o) == hv && steady_o, "R4 R8 hold stable", gain_o, hv);
    end
    ramp_down_i = 1'b1;
    @(negedge clk); ramp_down_i = 1'b0;
    chk(int'(gain_o) == hv && steady_o, "R5 trigger edge still holding", gain_o, hv);
    prev = hv;
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      e = ramp_exp(lvl, n, 1'b1);
      chk(iabs(int'(gain_o) - e) <= TOL && !steady_o, "R5 falling sample", gain_o, e);
      chk(int'(gain_o) <= prev, "R9 falling order", gain_o, prev);
      prev = int'(gain_o);
      if (poke && n == 50) begin ramp_down_i = 1'b1; ramp_up_i = 1'b1; end  // R8
      if (poke && n == 51) begin ramp_down_i = 1'b0; ramp_up_i = 1'b0; end
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(gain_o == 0 && steady_o, "R6 off after falling edge", gain_o, 0);
    end
    pwr_code_i = code;
  endtask

  task automatic t_repeat_identical(input logic [7:0] code);
    int mism;
    t_burst(code, 1'b0, -1);
    for (int n = 0; n < N; n++) ref_up[n] = cur_up[n];
    t_burst(code, 1'b0, -1);
    mism = 0;
    for (int n = 0; n < N; n++) if (ref_up[n] != cur_up[n]) mism++;
    chk(mism == 0, "R10 repeated burst identical (mismatches)", mism, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R3 act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_down_ignored();
    t_repeat_identical(8'h00);                  // full scale, R10
    t_burst(8'h08, 1'b1, level_exp(0));         // 2 dB, disturbed, R7 R8 R11
    t_burst(8'h03, 1'b0, level_exp(8));         // 0.75 dB fine step
    t_burst(8'h80, 1'b0, level_exp(3));         // 32 dB
    t_burst(8'hFF, 1'b0, -1);                   // capped at 32 dB
    t_burst(8'h87, 1'b0, -1);                   // coarse 16 + fine 7, capped
    t_burst(8'h2D, 1'b0, level_exp(128));       // coarse 5, fine 5
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule